// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits beside the fetch unit of a processor front end and keeps the first sixteen instruction bytes found at recently taken branch targets. Once the decode stage has worked out where a predicted-taken branch goes, it presents that target address to the block. On a hit the stored bytes leave combinationally in the same cycle and go straight to the decoders, so fetch does not lose a cycle waiting on the instruction cache. On a miss, fetch reads the instruction cache as usual, and the line it gets back is written into the block through the fill port.

The storage is fully associative and compares the whole address, with sixteen entries by default. A fill whose address is already held rewrites that entry. Otherwise the fill goes to the lowest-numbered empty entry. When every entry is in use, a round-robin pointer chooses the entry to evict. A single invalidate-all input empties the cache in one cycle. This is meant for events such as self-modifying code or a context switch.

Top module: `btic_top`

## Requirements
- R1: Every entry is invalid after reset, so every lookup misses until a fill has been taken.
- R2: A lookup with `lk_valid` high whose address equals the full address of a valid entry raises `lk_hit` in the same cycle. In that cycle `lk_bytes` carries that entry's sixteen bytes, with byte 0 in bits 7:0.
- R3: When `lk_hit` is low, `lk_bytes` is all zeros.
- R4: A fill is written at the clock edge that ends its cycle. A lookup of the same address in the fill's own cycle misses, and lookups from the next cycle on hit.
- R5: A fill to an address that a valid entry already holds replaces that entry's bytes. No second copy is made, no other entry is disturbed, and the replacement pointer does not move.
- R6: While any entry is invalid, a fill of a new address occupies an empty entry and evicts no valid address.
- R7: When all entries are valid, a fill of a new address evicts the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after the last entry, only on such evictions. Because empty entries are taken lowest index first, the first eviction after reset removes the address filled first, and the second eviction removes the address filled second.
- R8: When `inv_all` is high, every entry becomes invalid at the end of that cycle, and a lookup in that same cycle misses.
- R9: A fill presented in the same cycle as `inv_all` is discarded.
- R10: With `lk_valid` low, `lk_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_addr | input | ADDR_W (32) | Branch target address to look up |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_bytes | output | 8*LINE_BYTES (128) | Instruction bytes at the target on a hit, zero otherwise |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | ADDR_W (32) | Target address of the fill |
| fill_bytes | input | 8*LINE_BYTES (128) | Instruction bytes fetched at the target |
| inv_all | input | 1 | Invalidate every entry |

## Verification
Lookup results have zero latency. The bench therefore drives all inputs on the falling edge and samples `lk_hit` and `lk_bytes` a quarter period later, before the next rising edge. It compares them with a reference model that still holds the state from before that edge. Fills and invalidates take effect exactly one rising edge later. The model is updated only after that edge, so a lookup of a fill's address in the fill's own cycle is expected to miss and the same lookup in the next cycle is expected to hit. Eviction order is checked in the first cycle after each replacing fill, by probing the address that should have left and its neighbours.

// File: rtl/btic_pkg.sv
package btic_pkg;

  // What a fill does to the storage in the current cycle.
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_FREE   = 2'd2,
    FILL_EVICT  = 2'd3
  } fill_kind_e;

  // Next value of a modulo-n pointer.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/btic_match.sv
module btic_match #(
  parameter int N  = 16,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 en,
  input  logic [AW-1:0]        key,
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][AW-1:0] tags,
  output logic [N-1:0]         hits,
  output logic                 any,
  output logic [IW-1:0]        idx
);

  function automatic logic tag_eq(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a == b;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = en & valid[g] & tag_eq(tags[g], key);
  end

  assign any = |hits;

  // Entries are unique, so OR-ing the indices of the set bits encodes the hit.
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/btic_victim.sv
module btic_victim
  import btic_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid,
  input  logic          fill_go,
  input  logic          fill_hit,
  input  logic [IW-1:0] fill_hit_idx,
  output fill_kind_e    kind,
  output logic [IW-1:0] slot,
  output logic [IW-1:0] rr_ptr
);

  function automatic logic [IW-1:0] lowest_free(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v[i]) r = IW'(i);
    end
    return r;
  endfunction

  logic any_free;
  assign any_free = ~&valid;

  always_comb begin
    kind = FILL_NONE;
    slot = '0;
    if (fill_go) begin
      if (fill_hit) begin
        kind = FILL_UPDATE;
        slot = fill_hit_idx;
      end else if (any_free) begin
        kind = FILL_FREE;
        slot = lowest_free(valid);
      end else begin
        kind = FILL_EVICT;
        slot = rr_ptr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (kind == FILL_EVICT) begin
      rr_ptr <= IW'(wrap_inc(int'(rr_ptr), N));
    end
  end

endmodule

// File: rtl/btic_store.sv
module btic_store #(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int DW = 128,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_all,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [AW-1:0]        wr_tag,
  input  logic [DW-1:0]        wr_data,
  output logic [N-1:0]         valid,
  output logic [N-1:0][AW-1:0] tags,
  output logic [N-1:0][DW-1:0] data
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel;
    assign sel = wr_en & (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid[g] <= 1'b0;
        tags[g]  <= '0;
        data[g]  <= '0;
      end else if (clr_all) begin
        valid[g] <= 1'b0;
      end else if (sel) begin
        valid[g] <= 1'b1;
        tags[g]  <= wr_tag;
        data[g]  <= wr_data;
      end
    end
  end

endmodule

// File: rtl/btic_top.sv
module btic_top
  import btic_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int DW = 8 * LINE_BYTES,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DW-1:0]     lk_bytes,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DW-1:0]     fill_bytes,
  input  logic              inv_all
);

  logic [ENTRIES-1:0]             valid_vec;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_arr;
  logic [ENTRIES-1:0][DW-1:0]     data_arr;

  // Named internal events, brought out for the checker.
  logic [ENTRIES-1:0] lk_hits;
  logic               lk_any;
  logic [IW-1:0]      lk_idx;
  logic [ENTRIES-1:0] fl_hits;
  logic               fl_any;
  logic [IW-1:0]      fl_idx;
  logic               fill_go;
  fill_kind_e         fill_kind;
  logic [IW-1:0]      fill_slot;
  logic [IW-1:0]      rr_ptr;

  assign fill_go = fill_valid & ~inv_all;

  btic_match #(.N(ENTRIES), .AW(ADDR_W)) u_lk_match (
    .en(lk_valid), .key(lk_addr), .valid(valid_vec), .tags(tag_arr),
    .hits(lk_hits), .any(lk_any), .idx(lk_idx)
  );

  btic_match #(.N(ENTRIES), .AW(ADDR_W)) u_fl_match (
    .en(fill_valid), .key(fill_addr), .valid(valid_vec), .tags(tag_arr),
    .hits(fl_hits), .any(fl_any), .idx(fl_idx)
  );

  btic_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_vec), .fill_go(fill_go),
    .fill_hit(fl_any), .fill_hit_idx(fl_idx),
    .kind(fill_kind), .slot(fill_slot), .rr_ptr(rr_ptr)
  );

  btic_store #(.N(ENTRIES), .AW(ADDR_W), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(inv_all),
    .wr_en(fill_kind != FILL_NONE), .wr_idx(fill_slot),
    .wr_tag(fill_addr), .wr_data(fill_bytes),
    .valid(valid_vec), .tags(tag_arr), .data(data_arr)
  );

  // AND-OR read mux; a flush in the same cycle masks every hit.
  always_comb begin
    lk_bytes = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_bytes = lk_bytes | (data_arr[i] & {DW{lk_hits[i] & ~inv_all}});
    end
  end

  assign lk_hit = lk_any & ~inv_all;

endmodule

// File: rtl/btic_checker.sv
module btic_checker
  import btic_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_hit,
  input logic [DW-1:0] lk_bytes,
  input logic          inv_all,
  input logic [N-1:0]  valid_vec,
  input logic [N-1:0]  lk_hits,
  input fill_kind_e    fill_kind
);

  assert_single_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));

  assert_idle_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_bytes == '0));

  assert_flush_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> !lk_hit);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0));

  assert_evict_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_kind == FILL_EVICT) |-> (&valid_vec));

  assert_free_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_kind == FILL_FREE) |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

  assert_no_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_all |=> ($countones(valid_vec) >= $past($countones(valid_vec))));

  assert_flush_drops_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> (fill_kind == FILL_NONE));

endmodule

bind btic_top btic_checker #(.N(ENTRIES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_bytes(lk_bytes), .inv_all(inv_all), .valid_vec(valid_vec),
  .lk_hits(lk_hits), .fill_kind(fill_kind)
);

// File: tb/btic_top_test.sv
module btic_top_test;

  localparam int N  = 16;
  localparam int AW = 32;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_valid;
  logic [AW-1:0] lk_addr;
  logic          lk_hit;
  logic [DW-1:0] lk_bytes;
  logic          fill_valid;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_bytes;
  logic          inv_all;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  btic_top uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_bytes(lk_bytes), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .fill_bytes(fill_bytes), .inv_all(inv_all)
  );

  // Reference model built from the requirements.
  bit          m_valid [N];
  logic [AW-1:0] m_tag [N];
  logic [DW-1:0] m_data[N];
  int          m_ptr;

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic void m_fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int k;
    k = m_find(a);
    if (k < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) k = i;
    end
    if (k < 0) begin
      k = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_valid[k] = 1;
    m_tag[k]   = a;
    m_data[k]  = d;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) m_valid[i] = 0;
  endfunction

  function automatic logic [DW-1:0] rnd_line();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic compare(input string req, input logic eh, input logic [DW-1:0] ed);
    n_checks++;
    if (lk_hit !== eh || lk_bytes !== ed) begin
      n_errors++;
      $display("FAIL %s addr=%h actual hit=%b bytes=%h expected hit=%b bytes=%h",
               req, lk_addr, lk_hit, lk_bytes, eh, ed);
    end
  endtask

  // One cycle: drive at the falling edge, check the lookup before the rising edge,
  // then advance the model past that edge.
  task automatic step(input logic lkv, input logic [AW-1:0] la, input logic fv,
                      input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                      input logic inv, input string req);
    int k;
    logic eh;
    logic [DW-1:0] ed;
    @(negedge clk);
    lk_valid = lkv; lk_addr = la; fill_valid = fv; fill_addr = fa;
    fill_bytes = fd; inv_all = inv;
    #5;
    k  = m_find(la);
    eh = lkv && !inv && (k >= 0);
    ed = eh ? m_data[k] : '0;
    compare(req, eh, ed);
    @(posedge clk);
    #1;
    if (inv) m_clear();
    else if (fv) m_fill(fa, fd);
  endtask

  // Lookup only, with an expectation stated directly by the caller.
  task automatic probe(input logic [AW-1:0] a, input logic eh, input logic [DW-1:0] ed,
                       input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; fill_valid = 1'b0; inv_all = 1'b0;
    #5;
    compare(req, eh, ed);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  logic [AW-1:0] d  [N];
  logic [DW-1:0] dd [N];
  logic [DW-1:0] nd;
  logic [AW-1:0] x0, x1;
  logic [DW-1:0] xd0, xd1;

  initial begin
    void'($urandom(32'd7715));
    rst_n = 1'b0; lk_valid = 0; lk_addr = '0; fill_valid = 0;
    fill_addr = '0; fill_bytes = '0; inv_all = 0;
    m_clear(); m_ptr = 0;
    for (int i = 0; i < N; i++) begin
      d[i]  = 32'h0004_0000 + i * 32'h40;
      dd[i] = rnd_line();
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    probe(d[0], 1'b0, '0, "R1");
    probe(32'h0, 1'b0, '0, "R1");

    // R4: fill not visible in its own cycle, then R2 hit next cycle
    step(1'b1, d[0], 1'b1, d[0], dd[0], 1'b0, "R4");
    probe(d[0], 1'b1, dd[0], "R2");

    // R10: no hit without lk_valid
    step(1'b0, d[0], 1'b0, '0, '0, 1'b0, "R10");

    // R3: miss gives zero bytes
    probe(32'hDEAD_0000, 1'b0, '0, "R3");

    // R6: fill the remaining entries; nothing lost
    for (int i = 1; i < N; i++) step(1'b0, '0, 1'b1, d[i], dd[i], 1'b0, "R6");
    for (int i = 0; i < N; i++) probe(d[i], 1'b1, dd[i], "R6");

    // R5: in-place update of a held address
    nd = rnd_line();
    step(1'b0, '0, 1'b1, d[5], nd, 1'b0, "R5");
    dd[5] = nd;
    for (int i = 0; i < N; i++) probe(d[i], 1'b1, dd[i], "R5");

    // R7: round-robin eviction starts at entry 0 (first filled)
    x0 = 32'h0009_0000; xd0 = rnd_line();
    x1 = 32'h0009_1000; xd1 = rnd_line();
    step(1'b0, '0, 1'b1, x0, xd0, 1'b0, "R7");
    probe(d[0], 1'b0, '0, "R7");
    probe(x0, 1'b1, xd0, "R7");
    probe(d[1], 1'b1, dd[1], "R7");
    step(1'b0, '0, 1'b1, x1, xd1, 1'b0, "R7");
    probe(d[1], 1'b0, '0, "R7");
    probe(d[2], 1'b1, dd[2], "R7");
    probe(x1, 1'b1, xd1, "R7");

    // R8: flush misses in its own cycle, empties everything after
    step(1'b1, d[2], 1'b0, '0, '0, 1'b1, "R8");
    probe(d[2], 1'b0, '0, "R8");
    probe(x0, 1'b0, '0, "R8");

    // R9: fill with flush is dropped
    step(1'b0, '0, 1'b1, d[3], dd[3], 1'b1, "R9");
    probe(d[3], 1'b0, '0, "R9");

    // Constrained random traffic over a small address pool (R2 R4 R5 R7 R8)
    for (int c = 0; c < 4000; c++) begin
      logic [AW-1:0] ra, fa;
      logic lv, fv, iv;
      ra = 32'h0010_0000 + ($urandom % 24) * 32'h10;
      fa = 32'h0010_0000 + ($urandom % 24) * 32'h10;
      lv = ($urandom % 8) != 0;
      fv = ($urandom % 3) == 0;
      iv = ($urandom % 200) == 0;
      step(lv, ra, fv, fa, rnd_line(), iv, "R2");
    end

    done = 1;
    finish_run();
  end

endmodule